// File: doc/BRIEF.md
# Configurable SPI Word Shift Engine

This block moves one word at a time across a serial peripheral bus in full duplex. A caller presents a parallel transmit word, a word length, a clock divider, a mode byte and a direction bit, then pulses a start input. The engine generates the serial clock, drives the outgoing data line and samples the incoming one. When the word is complete it raises a one-cycle done pulse and presents the received word, right-justified. Every per-word setting is captured when the start pulse is accepted, so the caller may change its inputs while a word is in flight.

The mode byte selects the clock idle level and sampling phase, whether each word travels least-significant bit first, a half-duplex arrangement in which both directions share one data line, an internal loopback in which the engine receives its own transmitted bits, and a pause handshake in which the peripheral holds a ready line low to freeze the transfer. Chip selects, message sequencing and buffering are left to the surrounding logic.

Top module: `spi_word_shifter`

## Requirements
- R1: After reset, busy_o and done_o are 0, sdo_oe_o is 1, and sck_o equals mode_i bit 1 (clock idle level).
- R2: A start_i pulse while idle captures tx_word_i, tx_en_i, len_i, div_i, mode_i and dir_i, and busy_o is 1 from the next cycle. A start_i pulse while busy has no effect on the word in flight or on the words that follow.
- R3: Each serial clock half-period lasts div_i+1 system cycles. A word of W bits makes exactly 2W clock transitions and busy_o stays high for 2W(div_i+1) cycles. While idle, sck_o sits at mode_i bit 1, and it returns to that level when the word ends.
- R4: mode_i bit 0 selects phase. When it is 0, the first bit is on sdo_o before the first clock transition, the input is sampled on odd-numbered transitions and the output changes on even-numbered ones. When it is 1, the output changes on odd-numbered transitions and the input is sampled on even-numbered ones.
- R5: mode_i bit 3 set sends and receives bit 0 of the word first. When it is clear, bit W-1 goes first.
- R6: len_i gives W. A value of 0 means 8, values 1 to 32 are taken as given, and values above 32 mean 32. Transmit bits at or above W are never driven, and the received word is right-justified in rx_word_o bits W-1:0. Higher bits of rx_word_o carry no defined value.
- R7: With tx_en_i low at start, every bit driven on sdo_o is 0, and the word is still received in full.
- R8: mode_i bit 5 set makes the received word equal to the transmitted bits and ignores sdi_i.
- R9: mode_i bit 4 set selects one shared data line. With dir_i 0, sdo_oe_o is 0 for the whole word, zeros are sent, and data is taken from sdo_pad_i. With dir_i 1, the engine drives the line, and it reads back its own bits from sdo_pad_i. sdi_i is ignored in both cases. When bit 4 is clear, sdo_oe_o is 1.
- R10: With mode_i bit 7 set, each cycle in which ready_i is low freezes the transfer. sck_o holds and the word takes one extra cycle per frozen cycle. With bit 7 clear, ready_i has no effect.
- R11: When a word ends, busy_o falls and done_o is high for exactly one cycle, with rx_word_o holding the received word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a word (accepted only when idle) |
| tx_word_i | input | 32 | Parallel word to send, right-justified |
| tx_en_i | input | 1 | 0 sends zeros instead of tx_word_i |
| len_i | input | 6 | Word length, 0 means 8, above 32 means 32 |
| div_i | input | 8 | Half-period of the serial clock minus one, in system cycles |
| mode_i | input | 8 | bit0 phase, bit1 idle level, bit3 LSB first, bit4 shared line, bit5 loopback, bit7 pause enable |
| dir_i | input | 1 | Shared-line direction: 1 drive, 0 receive |
| ready_i | input | 1 | Peripheral ready, low pauses when enabled |
| sdi_i | input | 1 | Serial data in (separate-line mode) |
| sdo_pad_i | input | 1 | Value read back from the data-out pad (shared-line mode) |
| busy_o | output | 1 | Word in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_word_o | output | 32 | Received word, right-justified |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data-out pad |

## Verification
The assertions take for granted that mode_i does not change while a word is in flight, because the idle clock level follows the live mode input once busy_o falls. The bench therefore changes mode_i, and every other per-word input, only on a cycle before the start pulse and leaves it unchanged until the done pulse has passed. The assertions also expect start_i to be a pulse that is not offered in the first cycles after reset, while the internal reset release is still in progress. The bench waits several cycles after reset before its first start.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  localparam int MB_PHASE    = 0;
  localparam int MB_IDLE_HI  = 1;
  localparam int MB_LSB      = 3;
  localparam int MB_SHARED   = 4;
  localparam int MB_LOOP     = 5;
  localparam int MB_PAUSE_EN = 7;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } sh_state_e;
endpackage

// File: rtl/spi_edge_timer.sv
module spi_edge_timer #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            hold_i,
  input  logic [DIVW-1:0] div_i,
  output logic            edge_o
);
  logic [DIVW-1:0] tick_q, tick_d;
  logic            at_top;

  assign at_top = (tick_q == div_i);

  always_comb begin
    tick_d = tick_q;
    if (!run_i)       tick_d = '0;
    else if (!hold_i) tick_d = at_top ? '0 : tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  assign edge_o = run_i & ~hold_i & at_top;
endmodule

// File: rtl/spi_bit_pos.sv
module spi_bit_pos #(
  parameter int MAXW = 32,
  localparam int LENW = $clog2(MAXW + 1),
  localparam int IW   = $clog2(MAXW)
) (
  input  logic [LENW-1:0] len_i,
  input  logic [LENW-1:0] idx_i,
  input  logic            lsb_i,
  output logic [IW-1:0]   pos_o,
  output logic            ok_o
);
  logic [LENW-1:0] raw;
  logic            raw_unused;

  assign raw        = lsb_i ? idx_i : (len_i - 1'b1 - idx_i);
  assign ok_o       = (idx_i < len_i);
  assign pos_o      = raw[IW-1:0];
  assign raw_unused = ^raw;
endmodule

// File: rtl/spi_rx_collect.sv
module spi_rx_collect #(
  parameter int MAXW = 32,
  localparam int IW  = $clog2(MAXW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            cap_i,
  input  logic            pos_ok_i,
  input  logic [IW-1:0]   pos_i,
  input  logic            bit_i,
  output logic [MAXW-1:0] word_o
);
  for (genvar b = 0; b < MAXW; b++) begin : g_bit
    logic hit, bit_q;
    assign hit = cap_i & pos_ok_i & (pos_i == IW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bit_q <= 1'b0;
      else if (clear_i) bit_q <= 1'b0;
      else if (hit)     bit_q <= bit_i;
    end
    assign word_o[b] = bit_q;
  end
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_shift_pkg::*;
#(
  parameter int MAXW = 32,
  parameter int DIVW = 8,
  localparam int LENW = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [MAXW-1:0] tx_word_i,
  input  logic            tx_en_i,
  input  logic [LENW-1:0] len_i,
  input  logic [DIVW-1:0] div_i,
  input  logic [7:0]      mode_i,
  input  logic            dir_i,
  input  logic            ready_i,
  input  logic            sdi_i,
  input  logic            sdo_pad_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [MAXW-1:0] rx_word_o,
  output logic            sck_o,
  output logic            sdo_o,
  output logic            sdo_oe_o
);
  localparam int ECW    = LENW + 1;
  localparam int IW     = $clog2(MAXW);
  localparam int DEFLEN = (MAXW < 8) ? MAXW : 8;

  // reset release synchronizer
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // control state
  sh_state_e       state_q, state_d;
  logic [ECW-1:0]  ecnt_q, ecnt_d;
  logic            done_q, done_d;
  logic            load;

  // per-word settings captured at start
  logic [MAXW-1:0] tx_q;
  logic [LENW-1:0] len_q;
  logic [DIVW-1:0] div_q;
  logic            cpha_q, cpol_q, lsb_q, tw_q, loop_q, rdy_q, dir_q;

  logic [LENW-1:0] len_eff;
  logic            run, hold, edge_ev, last_edge, sample_ev;
  logic [ECW-1:0]  edge_total, oidx_w;
  logic [LENW-1:0] out_idx, in_idx;
  logic [IW-1:0]   tx_pos, rx_pos;
  logic            tx_ok, rx_ok, tx_bit, rx_bit;
  logic            aux_unused;

  always_comb begin
    if (len_i == '0)               len_eff = LENW'(DEFLEN);
    else if (int'(len_i) > MAXW)   len_eff = LENW'(MAXW);
    else                           len_eff = len_i;
  end

  assign run        = (state_q == SH_RUN);
  assign hold       = rdy_q & ~ready_i;
  assign edge_total = ECW'(len_q) << 1;
  assign last_edge  = edge_ev & (ecnt_q == edge_total - 1'b1);
  // phase 0 samples on odd transitions (count even before it), phase 1 on even
  assign sample_ev  = edge_ev & (ecnt_q[0] == cpha_q);

  always_comb begin
    state_d = state_q;
    ecnt_d  = ecnt_q;
    done_d  = 1'b0;
    load    = 1'b0;
    case (state_q)
      SH_IDLE: begin
        if (start_i) begin
          state_d = SH_RUN;
          ecnt_d  = '0;
          load    = 1'b1;
        end
      end
      SH_RUN: begin
        if (edge_ev) begin
          ecnt_d = ecnt_q + 1'b1;
          if (last_edge) begin
            state_d = SH_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= SH_IDLE;
      ecnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tx_q   <= '0;
      len_q  <= LENW'(DEFLEN);
      div_q  <= '0;
      cpha_q <= 1'b0;
      cpol_q <= 1'b0;
      lsb_q  <= 1'b0;
      tw_q   <= 1'b0;
      loop_q <= 1'b0;
      rdy_q  <= 1'b0;
      dir_q  <= 1'b1;
    end else if (load) begin
      tx_q   <= (tx_en_i && (!mode_i[MB_SHARED] || dir_i)) ? tx_word_i : '0;
      len_q  <= len_eff;
      div_q  <= div_i;
      cpha_q <= mode_i[MB_PHASE];
      cpol_q <= mode_i[MB_IDLE_HI];
      lsb_q  <= mode_i[MB_LSB];
      tw_q   <= mode_i[MB_SHARED];
      loop_q <= mode_i[MB_LOOP];
      rdy_q  <= mode_i[MB_PAUSE_EN];
      dir_q  <= dir_i;
    end
  end

  spi_edge_timer #(.DIVW(DIVW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run),
    .hold_i (hold),
    .div_i  (div_q),
    .edge_o (edge_ev)
  );

  // bit ordinal on the wire: phase 1 advances on leading edges after the first
  assign oidx_w  = (cpha_q && ecnt_q != '0) ? (ecnt_q - 1'b1) : ecnt_q;
  assign out_idx = oidx_w[ECW-1:1];
  assign in_idx  = ecnt_q[ECW-1:1];

  spi_bit_pos #(.MAXW(MAXW)) u_tx_pos (
    .len_i (len_q),
    .idx_i (out_idx),
    .lsb_i (lsb_q),
    .pos_o (tx_pos),
    .ok_o  (tx_ok)
  );

  spi_bit_pos #(.MAXW(MAXW)) u_rx_pos (
    .len_i (len_q),
    .idx_i (in_idx),
    .lsb_i (lsb_q),
    .pos_o (rx_pos),
    .ok_o  (rx_ok)
  );

  assign tx_bit = tx_ok & tx_q[tx_pos];
  assign rx_bit = loop_q ? tx_bit : (tw_q ? sdo_pad_i : sdi_i);

  spi_rx_collect #(.MAXW(MAXW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear_i  (load),
    .cap_i    (sample_ev),
    .pos_ok_i (rx_ok),
    .pos_i    (rx_pos),
    .bit_i    (rx_bit),
    .word_o   (rx_word_o)
  );

  assign busy_o     = run;
  assign done_o     = done_q;
  assign sck_o      = run ? (cpol_q ^ ecnt_q[0]) : mode_i[MB_IDLE_HI];
  assign sdo_o      = run & tx_bit;
  assign sdo_oe_o   = ~(tw_q & ~dir_q);
  assign aux_unused = mode_i[2] ^ mode_i[6] ^ oidx_w[0];
endmodule

// File: rtl/spi_word_shifter_chk.sv
module spi_word_shifter_chk #(
  parameter int MAXW = 32,
  localparam int LENW = $clog2(MAXW + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            sck_o,
  input logic            sdo_o,
  input logic            sdo_oe_o,
  input logic            ready_i,
  input logic            rdy_en,
  input logic            cpol_lat,
  input logic [LENW-1:0] len_lat
);
  localparam int CW = LENW + 2;

  logic          busy_prev, sck_prev;
  logic [CW-1:0] tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_prev <= 1'b0;
      sck_prev  <= 1'b0;
      tog_q     <= '0;
    end else begin
      busy_prev <= busy_o;
      sck_prev  <= sck_o;
      if (!busy_prev)             tog_q <= '0;
      else if (sck_o != sck_prev) tog_q <= tog_q + 1'b1;
    end
  end

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o && !busy_prev) |=> busy_o);

  assert_edge_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_prev && !busy_o) |-> ((tog_q + CW'(sck_o != sck_prev)) == (CW'(len_lat) << 1)));

  assert_sck_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (sck_o == cpol_lat));

  assert_quiet_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe_o |-> !sdo_o);

  assert_pause_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $past(rdy_en && !ready_i)) |-> $stable(sck_o));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind spi_word_shifter spi_word_shifter_chk #(.MAXW(MAXW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .sck_o    (sck_o),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o),
  .ready_i  (ready_i),
  .rdy_en   (rdy_q),
  .cpol_lat (cpol_q),
  .len_lat  (len_q)
);

// File: tb/tb_spi_word_shifter.sv
`timescale 1ns/1ps
module tb_spi_word_shifter;
  localparam int MAXW = 32;

  logic        clk = 1'b0;
  logic        rst_n, start_i, tx_en_i, dir_i, ready_i;
  logic [31:0] tx_word_i;
  logic [5:0]  len_i;
  logic [7:0]  div_i, mode_i;
  logic        sdi_i, sdo_pad_i;
  logic        busy_o, done_o, sck_o, sdo_o, sdo_oe_o;
  logic [31:0] rx_word_o;

  always #2.5 clk = ~clk;

  spi_word_shifter dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_word_i(tx_word_i),
    .tx_en_i(tx_en_i), .len_i(len_i), .div_i(div_i), .mode_i(mode_i),
    .dir_i(dir_i), .ready_i(ready_i), .sdi_i(sdi_i), .sdo_pad_i(sdo_pad_i),
    .busy_o(busy_o), .done_o(done_o), .rx_word_o(rx_word_o), .sck_o(sck_o),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // peripheral model
  int          nedge = 0;
  int          mw = 8;
  logic [31:0] sw = '0;
  logic [31:0] cap = '0;
  bit          m_cpha = 0, m_lsb = 0, m_alt = 0;
  logic        last_sck = 1'b0, last_sdo = 1'b0, prev_busy = 1'b0;
  logic        sbit;

  always @(negedge clk) begin
    if (busy_o || prev_busy) begin
      if (sck_o !== last_sck) begin
        nedge = nedge + 1;
        if (((nedge % 2) == 1) != m_cpha) begin
          int k;
          k = m_cpha ? (nedge / 2 - 1) : ((nedge - 1) / 2);
          if (k >= 0 && k < MAXW) cap[k] = last_sdo;
        end
      end
    end else begin
      nedge = 0;
    end
    prev_busy = busy_o;
    last_sck  = sck_o;
    last_sdo  = sdo_o;
  end

  always_comb begin
    int k;
    k = m_cpha ? ((nedge == 0) ? 0 : (nedge - 1) / 2) : nedge / 2;
    sbit = 1'b0;
    if (k < mw) sbit = m_lsb ? sw[k] : sw[mw-1-k];
  end

  assign sdi_i     = m_alt ? ~sbit : sbit;
  assign sdo_pad_i = sdo_oe_o ? sdo_o : sbit;

  // results of the last word
  int          g_cyc;
  bit          g_started, g_done, g_done2, g_busy2, g_oe_all, g_oe_any;
  logic [31:0] g_rx;

  task automatic run_word(input logic [31:0] tx, input int len, input int div,
                          input logic [7:0] mode, input bit txen, input bit dir,
                          input logic [31:0] slave, input int pstart, input int plen,
                          input int restart_at);
    @(negedge clk);
    tx_word_i = tx; len_i = len[5:0]; div_i = div[7:0]; mode_i = mode;
    tx_en_i = txen; dir_i = dir; sw = slave;
    mw = (len == 0) ? 8 : ((len > 32) ? 32 : len);
    m_cpha = mode[0]; m_lsb = mode[3]; m_alt = mode[4] | mode[5];
    cap = '0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    g_started = busy_o;
    g_cyc = 0; g_oe_all = 1; g_oe_any = 0;
    while (busy_o && g_cyc < 20000) begin
      g_cyc++;
      g_oe_all &= sdo_oe_o;
      g_oe_any |= sdo_oe_o;
      if (g_cyc == pstart) ready_i = 1'b0;
      if (g_cyc == pstart + plen) ready_i = 1'b1;
      start_i = (g_cyc == restart_at);
      if (g_cyc == restart_at) begin
        tx_word_i = ~tx; len_i = 6'd3; mode_i = mode;
      end
      @(negedge clk);
    end
    start_i = 1'b0; ready_i = 1'b1;
    g_done = done_o; g_rx = rx_word_o;
    @(negedge clk);
    g_done2 = done_o; g_busy2 = busy_o;
  endtask

  task automatic check_word(input string req, input logic [31:0] tx, input int div,
                            input bit lsb, input bit send, input logic [31:0] exp_rx,
                            input int extra);
    logic [31:0] mask, expw;
    mask = (mw == 32) ? 32'hFFFF_FFFF : ((32'h1 << mw) - 1);
    expw = '0;
    for (int k = 0; k < mw; k++) expw[k] = send ? (lsb ? tx[k] : tx[mw-1-k]) : 1'b0;
    chk(g_started, "R2", "busy after start", g_started, 1);
    chk(g_cyc == 2 * mw * (div + 1) + extra, "R3", "busy cycles", g_cyc,
        2 * mw * (div + 1) + extra);
    chk(g_done && !g_done2, "R11", "done pulse", {g_done, g_done2}, 2'b10);
    chk((g_rx & mask) == (exp_rx & mask), req, "rx word", g_rx & mask, exp_rx & mask);
    chk((cap & mask) == expw, req, "wire bits", cap & mask, expw);
  endtask

  task automatic t_reset;
    mode_i = 8'h00;
    #1;
    chk(!busy_o && !done_o, "R1", "busy/done at reset", {busy_o, done_o}, 0);
    chk(sdo_oe_o, "R1", "oe at reset", sdo_oe_o, 1);
    chk(sck_o == 1'b0, "R1", "sck idle low", sck_o, 0);
    mode_i = 8'h02;
    #1;
    chk(sck_o == 1'b1, "R1", "sck idle high", sck_o, 1);
    mode_i = 8'h00;
  endtask

  task automatic t_phases;
    // R4: all four phase/idle combinations, assorted dividers
    run_word(32'hA5C3_0F96, 8, 0, 8'h00, 1, 1, 32'h36, 0, 0, -1);
    check_word("R4", 32'hA5C3_0F96, 0, 0, 1, 32'h36, 0);
    run_word(32'h0000_003C, 8, 2, 8'h01, 1, 1, 32'hC5, 0, 0, -1);
    check_word("R4", 32'h3C, 2, 0, 1, 32'hC5, 0);
    run_word(32'h0000_0081, 8, 1, 8'h02, 1, 1, 32'h7E, 0, 0, -1);
    check_word("R4", 32'h81, 1, 0, 1, 32'h7E, 0);
    run_word(32'h0000_005A, 8, 3, 8'h03, 1, 1, 32'h93, 0, 0, -1);
    check_word("R4", 32'h5A, 3, 0, 1, 32'h93, 0);
  endtask

  task automatic t_lsb;
    run_word(32'hFFF0_0B4D, 12, 1, 8'h08, 1, 1, 32'h7E1, 0, 0, -1);
    check_word("R5", 32'hFFF0_0B4D, 1, 1, 1, 32'h7E1, 0);
    run_word(32'h0000_0B4D, 12, 0, 8'h09, 1, 1, 32'h2C6, 0, 0, -1);
    check_word("R5", 32'h0B4D, 0, 1, 1, 32'h2C6, 0);
  endtask

  task automatic t_length;
    run_word(32'h1234_56C9, 0, 0, 8'h00, 1, 1, 32'h5A, 0, 0, -1);
    check_word("R6", 32'h1234_56C9, 0, 0, 1, 32'h5A, 0);
    run_word(32'hFFFF_FFFE, 1, 1, 8'h00, 1, 1, 32'h1, 0, 0, -1);
    check_word("R6", 32'hFFFF_FFFE, 1, 0, 1, 32'h1, 0);
    run_word(32'hDEAD_BEEF, 32, 0, 8'h03, 1, 1, 32'h1357_9BDF, 0, 0, -1);
    check_word("R6", 32'hDEAD_BEEF, 0, 0, 1, 32'h1357_9BDF, 0);
    run_word(32'h8001_7FFE, 40, 0, 8'h00, 1, 1, 32'hF00D_4321, 0, 0, -1);
    check_word("R6", 32'h8001_7FFE, 0, 0, 1, 32'hF00D_4321, 0);
    run_word(32'hFFF9_2E17, 20, 1, 8'h01, 1, 1, 32'h8_A3C5, 0, 0, -1);
    check_word("R6", 32'hFFF9_2E17, 1, 0, 1, 32'h8_A3C5, 0);
  endtask

  task automatic t_no_tx;
    run_word(32'hFFFF_FFFF, 16, 0, 8'h00, 0, 1, 32'hC0DE, 0, 0, -1);
    check_word("R7", 32'hFFFF_FFFF, 0, 0, 0, 32'hC0DE, 0);
  endtask

  task automatic t_loop;
    run_word(32'h0000_006B, 8, 0, 8'h20, 1, 1, 32'h00, 0, 0, -1);
    check_word("R8", 32'h6B, 0, 0, 1, 32'h6B, 0);
    run_word(32'h0000_02D3, 10, 1, 8'h2B, 1, 1, 32'h155, 0, 0, -1);
    check_word("R8", 32'h2D3, 1, 1, 1, 32'h2D3, 0);
  endtask

  task automatic t_shared;
    run_word(32'h0000_FFFF, 12, 0, 8'h10, 1, 0, 32'hA6C, 0, 0, -1);
    check_word("R9", 32'hFFFF, 0, 0, 0, 32'hA6C, 0);
    chk(!g_oe_any, "R9", "oe low while receiving", g_oe_any, 0);
    run_word(32'h0000_0C35, 12, 1, 8'h11, 1, 1, 32'h3CA, 0, 0, -1);
    check_word("R9", 32'h0C35, 1, 0, 1, 32'h0C35, 0);
    chk(g_oe_all, "R9", "oe high while sending", g_oe_all, 1);
  endtask

  task automatic t_pause;
    run_word(32'h0000_00E2, 8, 1, 8'h80, 1, 1, 32'h4B, 5, 7, -1);
    check_word("R10", 32'hE2, 1, 0, 1, 32'h4B, 7);
    run_word(32'h0000_00E2, 8, 1, 8'h00, 1, 1, 32'h4B, 5, 7, -1);
    check_word("R10", 32'hE2, 1, 0, 1, 32'h4B, 0);
  endtask

  task automatic t_restart;
    run_word(32'h0000_0A3F, 12, 1, 8'h00, 1, 1, 32'h5C1, 0, 0, 6);
    check_word("R2", 32'h0A3F, 1, 0, 1, 32'h5C1, 0);
    chk(!g_busy2, "R2", "no restart after done", g_busy2, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; tx_en_i = 1'b1; dir_i = 1'b1; ready_i = 1'b1;
    tx_word_i = '0; len_i = '0; div_i = '0; mode_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_phases();
    t_lsb();
    t_length();
    t_no_tx();
    t_loop();
    t_shared();
    t_pause();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule